// File: doc/BRIEF.md
# Stack-Mode Forth ALU

This block is the arithmetic and logic unit of a two-stack processor in the Forth style. It keeps the top two cells of the data stack in registers, called TOS and NOS here, and holds deeper cells in a small register array. Each instruction has two parts: an operation code and a separate stack-mode field. For two-operand operations, the mode decides whether the operands are consumed and replaced by the result, or kept with the result pushed above them (the "2dup" form). The block updates TOS, NOS, the stack depth and four flags (carry, overflow, sign, zero) in the clock edge where `op_valid` is high.

A literal-push operation is how values enter the stack. The stack adjustment for the operation and mode now on the inputs appears on `sp_step` without any clock delay, so a neighbouring sequencer can use it. A push into a full stack, or a pop from an empty one, still completes, but it moves a two-state controller from `ST_CLEAN` to `ST_FAULTED` through transition `T_FAULT`. `ST_FAULTED` has only a self-loop, so only reset clears the error.

The stack holds 2**AW + 2 cells: TOS, NOS and 2**AW array cells. In the pairs below, n1 is NOS and n2 is TOS.

Top module: `fstk_alu`

## Requirements
- R1: After reset, `tos`, `nos`, `depth`, all four flags and `stk_err` are 0.
- R2: ADD (op 0) gives n1+n2 and ADC (op 1) gives n1+n2+carry. SUB (op 2) gives n1-n2 and SSUB (op 3) gives n2-n1. Carry takes the carry out of the adder; for the two subtracts this is 1 when no borrow occurs. Overflow takes the two's-complement overflow.
- R3: AND (op 4), OR (op 5) and XOR (op 6) give the bitwise result and leave carry and overflow unchanged.
- R4: A two-operand operation in any mode other than PUSH (mode 2) consumes n1 and n2 and places the result in TOS. Depth drops by one and NOS takes the next deeper cell, or 0 when no such cell exists.
- R5: A two-operand operation in PUSH mode (mode 2) keeps n1 and n2 and pushes the result. The new NOS is the old TOS, the old NOS moves into the array, and depth grows by one.
- R6: The following operations replace TOS in place and leave depth unchanged: invert (op 7), shift left (op 8), arithmetic shift right (op 9) and logical shift right (op 10). A left shift moves the old MSB into carry; a right shift moves the old LSB into carry. Overflow is unchanged.
- R7: Rotate right (op 11) and rotate left (op 12) rotate through carry. Rotate left feeds the old carry into bit 0 and moves the old MSB into carry. Rotate right feeds the old carry into the MSB and moves the old LSB into carry.
- R8: The zero test (op 13) replaces TOS with all ones if TOS was 0, and with 0 otherwise. It leaves carry and depth unchanged.
- R9: Op 14 depends on the mode. In PUSH mode (2) it pushes a copy of NOS. In POP mode (1) it removes NOS and keeps TOS. In NONE (0) or BOTH (3) it changes nothing on the stack.
- R10: Exchange (op 15) swaps TOS and NOS with no change in depth. Carry-clear (op 16) sets carry to 0 and leaves the stack as it was.
- R11: Literal (op 17) pushes `lit_data` in any mode. After every executed operation except op 16, the sign flag equals bit W-1 of the new TOS and the zero flag is 1 exactly when the new TOS is 0.
- R12: A push at depth 2**AW+2 or a pop at depth 0 sets `stk_err`. The operation still updates TOS and NOS, and depth stays within 0 to 2**AW+2. `stk_err` then stays at 1 until reset.
- R13: `sp_step` shows the depth change of the current `op_code` and `op_mode` with no clock delay, whether or not `op_valid` is high: 01 for +1, 11 for -1, 00 for none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Execute the operation on the inputs at this edge |
| op_code | input | 5 | Operation selector |
| op_mode | input | 2 | Stack mode: 0 NONE, 1 POP, 2 PUSH, 3 BOTH |
| lit_data | input | W | Value pushed by the literal operation |
| tos | output | W | Top of stack |
| nos | output | W | Next of stack |
| depth | output | $clog2(2**AW+3) | Number of cells on the stack |
| sp_step | output | 2 | Depth change of the current operation, two's complement |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_n | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| stk_err | output | 1 | Sticky stack fault |

## Verification
Some properties are checked at every cycle. Depth stays within capacity, the fault stays set, the operands exchange correctly, and every push moves the old TOS into NOS. Logical operations leave carry and overflow unchanged, the zero test gives only all ones or zero, carry-clear empties carry, and `sp_step` never shows the value 10. Other results can only be shown by the directed scenarios with values worked out by hand. These are the arithmetic values and flags, the rotates through carry, the refill of NOS from the array after a pop, the three behaviours of op 14, and the fault at the exact full and empty boundaries.

// File: rtl/fstk_alu_pkg.sv
package fstk_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SSUB = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_NOT  = 5'd7,
        OP_SL   = 5'd8,
        OP_ASR  = 5'd9,
        OP_LSR  = 5'd10,
        OP_ROR  = 5'd11,
        OP_ROL  = 5'd12,
        OP_ZEQU = 5'd13,
        OP_NOS  = 5'd14,
        OP_SWAP = 5'd15,
        OP_CC   = 5'd16,
        OP_LIT  = 5'd17
    } alu_op_e;

    typedef enum logic [1:0] {
        MD_NONE = 2'd0,
        MD_POP  = 2'd1,
        MD_PUSH = 2'd2,
        MD_BOTH = 2'd3
    } stk_mode_e;

    typedef enum logic {
        ST_CLEAN   = 1'b0,
        ST_FAULTED = 1'b1
    } err_state_e;

    localparam logic [1:0] STEP_UP   = 2'b01;
    localparam logic [1:0] STEP_DOWN = 2'b11;
    localparam logic [1:0] STEP_HOLD = 2'b00;

    function automatic logic [1:0] stack_step(alu_op_e op, stk_mode_e md);
        logic [1:0] s;
        s = STEP_HOLD;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SSUB, OP_AND, OP_OR, OP_XOR:
                s = (md == MD_PUSH) ? STEP_UP : STEP_DOWN;
            OP_NOS:
                s = (md == MD_PUSH) ? STEP_UP : ((md == MD_POP) ? STEP_DOWN : STEP_HOLD);
            OP_LIT:
                s = STEP_UP;
            default:
                s = STEP_HOLD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fstk_alu_calc.sv
module fstk_alu_calc
    import fstk_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  stk_mode_e      md,
    input  logic [W-1:0]   tos_in,
    input  logic [W-1:0]   nos_in,
    input  logic [W-1:0]   lit_in,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           c_out,
    output logic           c_we,
    output logic           v_out,
    output logic           v_we
);
    localparam int M = W - 1;

    logic [W:0]   ext;
    logic [W-1:0] opa;
    logic [W-1:0] opb;

    always_comb begin
        res   = tos_in;
        c_out = cin;
        c_we  = 1'b0;
        v_out = 1'b0;
        v_we  = 1'b0;
        opa   = nos_in;
        opb   = tos_in;
        ext   = '0;
        case (op)
            OP_ADD, OP_ADC: begin
                ext   = {1'b0, opa} + {1'b0, opb}
                      + {{W{1'b0}}, (op == OP_ADC) ? cin : 1'b0};
                res   = ext[W-1:0];
                c_out = ext[W];
                c_we  = 1'b1;
                v_out = (opa[M] == opb[M]) && (res[M] != opa[M]);
                v_we  = 1'b1;
            end
            OP_SUB, OP_SSUB: begin
                if (op == OP_SSUB) begin
                    opa = tos_in;
                    opb = nos_in;
                end
                ext   = {1'b0, opa} + {1'b0, ~opb} + {{W{1'b0}}, 1'b1};
                res   = ext[W-1:0];
                c_out = ext[W];
                c_we  = 1'b1;
                v_out = (opa[M] != opb[M]) && (res[M] != opa[M]);
                v_we  = 1'b1;
            end
            OP_AND:  res = nos_in & tos_in;
            OP_OR:   res = nos_in | tos_in;
            OP_XOR:  res = nos_in ^ tos_in;
            OP_NOT:  res = ~tos_in;
            OP_SL: begin
                res   = {tos_in[M-1:0], 1'b0};
                c_out = tos_in[M];
                c_we  = 1'b1;
            end
            OP_ASR: begin
                res   = {tos_in[M], tos_in[M:1]};
                c_out = tos_in[0];
                c_we  = 1'b1;
            end
            OP_LSR: begin
                res   = {1'b0, tos_in[M:1]};
                c_out = tos_in[0];
                c_we  = 1'b1;
            end
            OP_ROR: begin
                res   = {cin, tos_in[M:1]};
                c_out = tos_in[0];
                c_we  = 1'b1;
            end
            OP_ROL: begin
                res   = {tos_in[M-1:0], cin};
                c_out = tos_in[M];
                c_we  = 1'b1;
            end
            OP_ZEQU: res = (tos_in == '0) ? '1 : '0;
            OP_NOS:  res = (md == MD_PUSH) ? nos_in : tos_in;
            OP_SWAP: res = nos_in;
            OP_CC: begin
                c_out = 1'b0;
                c_we  = 1'b1;
            end
            OP_LIT:  res = lit_in;
            default: res = tos_in;
        endcase
    end

endmodule

// File: rtl/fstk_alu_stack.sv
module fstk_alu_stack #(
    parameter int W  = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    localparam int CELLS = 2 ** AW;

    logic [W-1:0] cells [CELLS];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/fstk_alu.sv
module fstk_alu
    import fstk_alu_pkg::*;
#(
    parameter int  W   = 32,
    parameter int  AW  = 6,
    localparam int CAP = 2 ** AW + 2,
    localparam int DW  = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [4:0]    op_code,
    input  logic [1:0]    op_mode,
    input  logic [W-1:0]  lit_data,
    output logic [W-1:0]  tos,
    output logic [W-1:0]  nos,
    output logic [DW-1:0] depth,
    output logic [1:0]    sp_step,
    output logic          flag_c,
    output logic          flag_v,
    output logic          flag_n,
    output logic          flag_z,
    output logic          stk_err
);
    localparam logic [DW-1:0] D_CAP = DW'(CAP);

    alu_op_e    op;
    stk_mode_e  md;
    err_state_e state_q, state_d;

    logic [W-1:0]  res, deep_rd, tos_d, nos_d;
    logic [DW-1:0] depth_d;
    logic          c_out, c_we, v_out, v_we;
    logic          do_push, do_pop, is_full, is_empty, fault;
    logic          mem_we;
    logic [AW-1:0] wr_addr, rd_addr;

    assign op = alu_op_e'(op_code);
    assign md = stk_mode_e'(op_mode);

    fstk_alu_calc #(.W(W)) u_calc (
        .op     (op),
        .md     (md),
        .tos_in (tos),
        .nos_in (nos),
        .lit_in (lit_data),
        .cin    (flag_c),
        .res    (res),
        .c_out  (c_out),
        .c_we   (c_we),
        .v_out  (v_out),
        .v_we   (v_we)
    );

    fstk_alu_stack #(.W(W), .AW(AW)) u_stack (
        .clk     (clk),
        .we      (mem_we),
        .wr_addr (wr_addr),
        .wr_data (nos),
        .rd_addr (rd_addr),
        .rd_data (deep_rd)
    );

    // stack bookkeeping for the current operation
    always_comb begin
        sp_step  = stack_step(op, md);
        do_push  = (sp_step == STEP_UP);
        do_pop   = (sp_step == STEP_DOWN);
        is_full  = (depth == D_CAP);
        is_empty = (depth == '0);
        fault    = op_valid && ((do_push && is_full) || (do_pop && is_empty));
        wr_addr  = AW'(depth - DW'(2));
        rd_addr  = AW'(depth - DW'(3));
        mem_we   = op_valid && do_push && !is_full && (depth >= DW'(2));

        tos_d   = res;
        nos_d   = nos;
        depth_d = depth;
        if (op == OP_SWAP) begin
            nos_d = tos;
        end else if (do_push) begin
            nos_d = tos;
            if (!is_full) depth_d = depth + DW'(1);
        end else if (do_pop) begin
            nos_d = (depth >= DW'(3)) ? deep_rd : '0;
            if (!is_empty) depth_d = depth - DW'(1);
        end
    end

    // state register of the fault controller
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: T_FAULT from clean, self-loop once faulted
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN:   if (fault) state_d = ST_FAULTED;
            ST_FAULTED: state_d = ST_FAULTED;
        endcase
    end

    // outputs of the fault controller
    always_comb begin
        stk_err = 1'b0;
        unique case (state_q)
            ST_CLEAN:   stk_err = 1'b0;
            ST_FAULTED: stk_err = 1'b1;
        endcase
    end

    // datapath registers and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tos    <= '0;
            nos    <= '0;
            depth  <= '0;
            flag_c <= 1'b0;
            flag_v <= 1'b0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
        end else if (op_valid) begin
            tos   <= tos_d;
            nos   <= nos_d;
            depth <= depth_d;
            if (c_we) flag_c <= c_out;
            if (v_we) flag_v <= v_out;
            if (op != OP_CC) begin
                flag_n <= tos_d[W-1];
                flag_z <= (tos_d == '0);
            end
        end
    end

endmodule

// File: rtl/fstk_alu_chk.sv
module fstk_alu_chk
    import fstk_alu_pkg::*;
#(
    parameter int  W   = 32,
    parameter int  AW  = 6,
    localparam int CAP = 2 ** AW + 2,
    localparam int DW  = $clog2(CAP + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [4:0]    op_code,
    input logic [W-1:0]  tos,
    input logic [W-1:0]  nos,
    input logic [DW-1:0] depth,
    input logic [1:0]    sp_step,
    input logic          flag_c,
    input logic          flag_v,
    input logic          stk_err
);

    AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DW'(CAP)); // R12

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err |=> stk_err); // R12

    AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR)
        |=> $stable(flag_c) && $stable(flag_v)); // R3

    AST_POP_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && sp_step == 2'b11 && depth != '0
        |=> depth == DW'($past(depth) - DW'(1))); // R4

    AST_PUSH_NOS: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && sp_step == 2'b01 |=> nos == $past(tos)); // R5

    AST_ZEQU_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_ZEQU |=> (tos == '0) || (tos == '1)); // R8

    AST_SWAP_XCHG: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_SWAP
        |=> tos == $past(nos) && nos == $past(tos)); // R10

    AST_CC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_CC |=> !flag_c); // R10

    AST_STEP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        sp_step != 2'b10); // R13

endmodule

bind fstk_alu fstk_alu_chk #(.W(W), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .tos      (tos),
    .nos      (nos),
    .depth    (depth),
    .sp_step  (sp_step),
    .flag_c   (flag_c),
    .flag_v   (flag_v),
    .stk_err  (stk_err)
);

// File: tb/fstk_alu_bench.sv
`timescale 1ns/1ps
module fstk_alu_bench;
    localparam int W   = 32;
    localparam int AW  = 2;
    localparam int CAP = 2 ** AW + 2;
    localparam int DW  = $clog2(CAP + 1);

    localparam logic [4:0] C_ADD = 5'd0,  C_ADC = 5'd1,  C_SUB = 5'd2,  C_SSUB = 5'd3;
    localparam logic [4:0] C_AND = 5'd4,  C_OR  = 5'd5,  C_XOR = 5'd6,  C_NOT  = 5'd7;
    localparam logic [4:0] C_SL  = 5'd8,  C_ASR = 5'd9,  C_LSR = 5'd10, C_ROR  = 5'd11;
    localparam logic [4:0] C_ROL = 5'd12, C_ZEQ = 5'd13, C_NOS = 5'd14, C_SWP  = 5'd15;
    localparam logic [4:0] C_CC  = 5'd16, C_LIT = 5'd17;
    localparam logic [1:0] M_NONE = 2'd0, M_POP = 2'd1, M_PUSH = 2'd2, M_BOTH = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [4:0]    op_code = '0;
    logic [1:0]    op_mode = '0;
    logic [W-1:0]  lit_data = '0;
    logic [W-1:0]  tos, nos;
    logic [DW-1:0] depth;
    logic [1:0]    sp_step;
    logic          flag_c, flag_v, flag_n, flag_z, stk_err;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    fstk_alu #(.W(W), .AW(AW)) u_fstk_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_mode(op_mode), .lit_data(lit_data), .tos(tos), .nos(nos),
        .depth(depth), .sp_step(sp_step), .flag_c(flag_c), .flag_v(flag_v),
        .flag_n(flag_n), .flag_z(flag_z), .stk_err(stk_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        op_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic exec(input logic [4:0] code, input logic [1:0] mode, input logic [W-1:0] lit);
        op_code  = code;
        op_mode  = mode;
        lit_data = lit;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic push(input logic [W-1:0] v);
        exec(C_LIT, M_NONE, v);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 tos", tos, 0);
        chk("R1 nos", nos, 0);
        chk("R1 depth", depth, 0);
        chk("R1 flags", {flag_c, flag_v, flag_n, flag_z}, 0);
        chk("R1 err", stk_err, 0);
    endtask

    task automatic t_arith();
        do_reset(); push(5); push(3);
        exec(C_SUB, M_POP, 0);
        chk("R2 sub", tos, 2);
        chk("R2 sub carry", flag_c, 1);
        chk("R4 sub depth", depth, 1);
        chk("R4 sub nos", nos, 0);
        do_reset(); push(5); push(3);
        exec(C_SSUB, M_POP, 0);
        chk("R2 ssub", tos, 32'hFFFF_FFFE);
        chk("R2 ssub carry", flag_c, 0);
        chk("R11 ssub sign", flag_n, 1);
        do_reset(); push(32'h7FFF_FFFF); push(1);
        exec(C_ADD, M_POP, 0);
        chk("R2 add ovf value", tos, 32'h8000_0000);
        chk("R2 add ovf flag", {flag_c, flag_v}, 2'b01);
        do_reset(); push(32'hFFFF_FFFF); push(1);
        exec(C_ADD, M_PUSH, 0);
        chk("R5 push result", tos, 0);
        chk("R5 push nos", nos, 1);
        chk("R5 push depth", depth, 3);
        chk("R2 add carry", {flag_c, flag_v, flag_z}, 3'b101);
        exec(C_ADC, M_POP, 0);
        chk("R2 adc", tos, 2);
        chk("R2 adc carry", flag_c, 0);
        chk("R4 refill nos", nos, 32'hFFFF_FFFF);
        chk("R4 adc depth", depth, 2);
    endtask

    task automatic t_logic();
        do_reset(); push(32'h7FFF_FFFF); push(1);
        exec(C_ADD, M_POP, 0);
        exec(C_SL, M_NONE, 0);
        chk("R6 sl", tos, 0);
        chk("R6 sl flags", {flag_c, flag_v}, 2'b11);
        push(32'hFF);
        exec(C_XOR, M_POP, 0);
        chk("R3 xor", tos, 32'hFF);
        chk("R3 xor flags", {flag_c, flag_v}, 2'b11);
        push(32'h0F);
        exec(C_AND, M_PUSH, 0);
        chk("R3 and push", {tos, nos}, {32'h0F, 32'h0F});
        chk("R5 and depth", depth, 3);
        exec(C_OR, M_POP, 0);
        chk("R3 or", {tos, nos}, {32'h0F, 32'hFF});
        chk("R3 or flags", {flag_c, flag_v}, 2'b11);
        do_reset(); push(6); push(4);
        exec(C_AND, M_BOTH, 0);
        chk("R4 both mode", {tos, 32'(depth)}, {32'h4, 32'h1});
    endtask

    task automatic t_shift();
        do_reset(); push(32'h8000_0001);
        exec(C_ASR, M_NONE, 0);
        chk("R6 asr", {tos, 31'h0, flag_c}, {32'hC000_0000, 32'h1});
        exec(C_LSR, M_NONE, 0);
        chk("R6 lsr", {tos, 31'h0, flag_c}, {32'h6000_0000, 32'h0});
        exec(C_NOT, M_NONE, 0);
        chk("R6 not", tos, 32'h9FFF_FFFF);
        chk("R6 depth", depth, 1);
    endtask

    task automatic t_rotate();
        do_reset(); push(32'h8000_0000);
        exec(C_ROL, M_NONE, 0);
        chk("R7 rol 1", {tos, 31'h0, flag_c}, {32'h0, 32'h1});
        exec(C_ROL, M_NONE, 0);
        chk("R7 rol 2", {tos, 31'h0, flag_c}, {32'h1, 32'h0});
        exec(C_ROR, M_NONE, 0);
        chk("R7 ror 1", {tos, 31'h0, flag_c}, {32'h0, 32'h1});
        exec(C_ROR, M_NONE, 0);
        chk("R7 ror 2", {tos, 31'h0, flag_c}, {32'h8000_0000, 32'h0});
    endtask

    task automatic t_zequ();
        do_reset(); push(32'h8000_0000);
        exec(C_SL, M_NONE, 0);
        exec(C_ZEQ, M_NONE, 0);
        chk("R8 zero in", tos, 32'hFFFF_FFFF);
        chk("R8 carry kept", flag_c, 1);
        exec(C_ZEQ, M_NONE, 0);
        chk("R8 nonzero in", tos, 0);
        chk("R8 depth", depth, 1);
    endtask

    task automatic t_nos();
        do_reset(); push(1); push(2);
        exec(C_NOS, M_PUSH, 0);
        chk("R9 over", {tos, nos, 32'(depth)}, {32'd1, 32'd2, 32'd3});
        exec(C_NOS, M_NONE, 0);
        chk("R9 none", {tos, nos, 32'(depth)}, {32'd1, 32'd2, 32'd3});
        exec(C_NOS, M_POP, 0);
        chk("R9 nip", {tos, nos, 32'(depth)}, {32'd1, 32'd1, 32'd2});
    endtask

    task automatic t_swap_cc();
        do_reset(); push(1); push(2);
        exec(C_SWP, M_NONE, 0);
        chk("R10 swap", {tos, nos, 32'(depth)}, {32'd1, 32'd2, 32'd2});
        push(32'h8000_0000);
        exec(C_SL, M_NONE, 0);
        push(5);
        exec(C_CC, M_NONE, 0);
        chk("R10 cc carry", flag_c, 0);
        chk("R10 cc stack", {tos, nos, 32'(depth)}, {32'd5, 32'd0, 32'd4});
    endtask

    task automatic t_lit();
        do_reset();
        push(0);
        chk("R11 lit zero", {tos, 30'h0, flag_n, flag_z}, {32'h0, 32'h1});
        push(32'h8000_0000);
        chk("R11 lit sign", {tos, 30'h0, flag_n, flag_z}, {32'h8000_0000, 32'h2});
        chk("R11 lit depth", depth, 2);
    endtask

    task automatic t_error();
        do_reset();
        exec(C_ADD, M_POP, 0);
        chk("R12 underflow", {31'h0, stk_err, 32'(depth)}, {32'h1, 32'h0});
        push(9);
        chk("R12 sticky", {31'h0, stk_err, tos}, {32'h1, 32'h9});
        do_reset();
        chk("R12 reset clears", stk_err, 0);
        for (int i = 1; i <= CAP; i++) push(W'(i));
        chk("R12 full no err", {31'h0, stk_err, 32'(depth)}, {32'h0, 32'(CAP)});
        push(W'(CAP + 1));
        chk("R12 overflow", {31'h0, stk_err, 32'(depth)}, {32'h1, 32'(CAP)});
        chk("R12 op completes", {tos, nos}, {32'(CAP + 1), 32'(CAP)});
        exec(C_ADD, M_POP, 0);
        chk("R12 pop after full", {tos, 32'(depth)}, {32'(2 * CAP + 1), 32'(CAP - 1)});
    endtask

    task automatic t_step();
        do_reset();
        op_valid = 1'b0;
        op_code = C_ADD; op_mode = M_PUSH; #1;
        chk("R13 push step", sp_step, 2'b01);
        op_mode = M_POP; #1;
        chk("R13 pop step", sp_step, 2'b11);
        op_code = C_NOT; #1;
        chk("R13 unary step", sp_step, 2'b00);
        op_code = C_LIT; op_mode = M_BOTH; #1;
        chk("R13 lit step", sp_step, 2'b01);
        op_code = C_NOS; op_mode = M_NONE; #1;
        chk("R13 nos none step", sp_step, 2'b00);
        @(negedge clk);
        chk("R13 no exec", depth, 0);
    endtask

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_arith();
        t_logic();
        t_shift();
        t_rotate();
        t_zequ();
        t_nos();
        t_swap_cc();
        t_lit();
        t_error();
        t_step();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule